// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block is the per-processor front end of an interrupt controller. The distributor gives it a vector of pending interrupt IDs, a priority value for each ID, and the sending CPU number for each software-generated ID. From these the block picks the best eligible interrupt and raises a request line to the processor. Software reads an acknowledge register to learn which interrupt to service. It later writes an end-of-interrupt word to retire that interrupt.

Every acknowledge read that returns a real interrupt marks its ID active and pulses an acknowledge handshake towards the distributor. An accepted end-of-interrupt write clears the active mark and pulses a retire handshake. An ID that is active is never offered again until it is retired. A priority mask and an enable bit decide which interrupts may be signalled at all. All registers sit behind a small select/read/write port with combinational read data.

Top module: `cpu_if_core`

## Requirements
- R1: After reset the enable bit is 0 and the priority mask is 0xF0. No ID is active and `irq_o` is low. Register select 0 (control) reads 0 and select 1 (mask) reads 0xF0.
- R2: An ID is eligible when it is pending, not active, its priority is strictly below the mask, and it is no greater than both 510 and NUM_IDS-1. `irq_o` is high exactly when the enable bit is set and some ID is eligible.
- R3: Among eligible IDs the one with the smallest priority value wins. Ties go to the smallest ID.
- R4: A read of select 2 (acknowledge) while `irq_o` is high returns the winner's acknowledge word in that cycle. In the same cycle it pulses `ack_o` with `ack_id_o` equal to the winner, and the winner is active from the next cycle on.
- R5: A read of select 2 while the enable bit is clear or nothing is eligible returns 1023. It does not pulse `ack_o` and changes no active bit.
- R6: The acknowledge word carries the ID in bits 9:0. For IDs 0 to 15 it carries that ID's source CPU from `sgi_src_i` in bits 12:10. Those bits are 0 for other IDs, and bits 31:13 are always 0.
- R7: A write to select 3 (end-of-interrupt) retires an ID when the word equals the acknowledge word that ID was acknowledged with, and the ID is active. It pulses `eoi_o` with `eoi_id_o` in that cycle, and the active bit clears in the next cycle.
- R8: An end-of-interrupt word that names an inactive ID, or differs from the recorded acknowledge word in any bit, has no effect. `eoi_o` stays low and every active bit is kept.
- R9: Pending IDs above 510 are never signalled or acknowledged.
- R10: Bit 0 of select 0 is the enable bit. Select 1 stores the low PRIO_W bits of the written data, and both selects read back what they hold.
- R11: An active ID is not signalled again while it stays pending. It becomes eligible again as soon as it is retired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NUM_IDS | Pending flag per ID from the distributor |
| prio_i | input | NUM_IDS*PRIO_W | Priority per ID, ID n at bits n*PRIO_W upward |
| sgi_src_i | input | 16*CPU_W | Source CPU per software-generated ID |
| reg_sel_i | input | 2 | Register select: 0 control, 1 mask, 2 acknowledge, 3 end-of-interrupt |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_o | output | 1 | Acknowledge handshake to the distributor |
| ack_id_o | output | 10 | ID being acknowledged |
| eoi_o | output | 1 | Retire handshake to the distributor |
| eoi_id_o | output | 10 | ID being retired |
| active_o | output | NUM_IDS | Active flag per ID |

## Verification
The delicate overlap is a retirement that lands in a cycle where the same ID is still pending at the distributor. The active bit clears at the very edge where the ID must become a candidate again. The bench keeps an ID pending, acknowledges it, and confirms the request line drops. It then writes the matching end-of-interrupt word and checks that the request line is back in the next sampled cycle and that a fresh acknowledge returns the same ID. Random runs also change pending vectors, priorities and source numbers just before acknowledge reads and mixed good and corrupted retire words. Each outcome is judged against a reference model of the eligibility and winner rules.

// File: rtl/cif_pkg.sv
package cif_pkg;
    localparam int ID_W    = 10;
    localparam int SGI_N   = 16;
    localparam int ID_CAP  = 510;
    localparam int SRC_LSB = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_PMASK = 2'd1,
        SEL_ACK   = 2'd2,
        SEL_EOI   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cif_select.sv
module cif_select
    import cif_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int PRIO_W  = 8
) (
    input  logic [NUM_IDS-1:0]        pend_i,
    input  logic [NUM_IDS*PRIO_W-1:0] prio_i,
    input  logic [NUM_IDS-1:0]        active_i,
    input  logic [PRIO_W-1:0]         pmask_i,
    output logic                      found_o,
    output logic [ID_W-1:0]           win_id_o
);
    localparam int LAST_ID = (NUM_IDS - 1 > ID_CAP) ? ID_CAP : NUM_IDS - 1;

    logic [NUM_IDS-1:0] elig;
    logic [PRIO_W-1:0]  best;
    logic [PRIO_W-1:0]  cur;

    // one eligibility term per ID; IDs beyond the cap are tied off
    for (genvar g = 0; g < NUM_IDS; g++) begin : g_elig
        if (g <= LAST_ID) begin : g_live
            assign elig[g] = pend_i[g] && !active_i[g]
                             && (prio_i[g*PRIO_W +: PRIO_W] < pmask_i);
        end else begin : g_capped
            assign elig[g] = 1'b0;
        end
    end

    // strict compare keeps the lowest ID on equal priority
    always_comb begin
        found_o  = 1'b0;
        win_id_o = '0;
        best     = '1;
        cur      = '0;
        for (int i = 0; i < NUM_IDS; i++) begin
            cur = prio_i[i*PRIO_W +: PRIO_W];
            if (elig[i] && (!found_o || cur < best)) begin
                found_o  = 1'b1;
                best     = cur;
                win_id_o = i[ID_W-1:0];
            end
        end
    end
endmodule

// File: rtl/cif_ack_fmt.sv
module cif_ack_fmt
    import cif_pkg::*;
#(
    parameter int CPU_W = 3
) (
    input  logic                   grant_i,
    input  logic [ID_W-1:0]        win_id_i,
    input  logic [SGI_N*CPU_W-1:0] sgi_src_i,
    output logic [CPU_W-1:0]       src_o,
    output logic [31:0]            word_o
);
    always_comb begin
        src_o  = '0;
        word_o = 32'(SPURIOUS_ID);
        if (grant_i) begin
            if (win_id_i < ID_W'(SGI_N)) begin
                src_o = sgi_src_i[win_id_i[3:0]*CPU_W +: CPU_W];
            end
            word_o = 32'(win_id_i);
            word_o[SRC_LSB +: CPU_W] = src_o;
        end
    end
endmodule

// File: rtl/cpu_if_core.sv
module cpu_if_core
    import cif_pkg::*;
#(
    parameter int NUM_IDS   = 64,
    parameter int PRIO_W    = 8,
    parameter int CPU_W     = 3,
    parameter int PMASK_RST = 240
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IDS-1:0]        pend_i,
    input  logic [NUM_IDS*PRIO_W-1:0] prio_i,
    input  logic [SGI_N*CPU_W-1:0]    sgi_src_i,
    input  logic [1:0]                reg_sel_i,
    input  logic                      reg_rd_i,
    input  logic                      reg_wr_i,
    input  logic [31:0]               reg_wdata_i,
    output logic [31:0]               reg_rdata_o,
    output logic                      irq_o,
    output logic                      ack_o,
    output logic [ID_W-1:0]           ack_id_o,
    output logic                      eoi_o,
    output logic [ID_W-1:0]           eoi_id_o,
    output logic [NUM_IDS-1:0]        active_o
);
    typedef struct packed {
        logic                   en;
        logic [PRIO_W-1:0]      pmask;
        logic [NUM_IDS-1:0]     active;
        logic [SGI_N*CPU_W-1:0] src;    // source seen at acknowledge, per SGI
    } state_t;

    state_t s_d, s_q;

    logic             found;
    logic             grant;
    logic [ID_W-1:0]  win_id;
    logic [CPU_W-1:0] ack_src;
    logic [31:0]      ack_word;
    logic [ID_W-1:0]  e_id;
    logic [31:0]      e_expect;
    logic             e_hit;

    cif_select #(
        .NUM_IDS (NUM_IDS),
        .PRIO_W  (PRIO_W)
    ) u_select (
        .pend_i   (pend_i),
        .prio_i   (prio_i),
        .active_i (s_q.active),
        .pmask_i  (s_q.pmask),
        .found_o  (found),
        .win_id_o (win_id)
    );

    assign grant = found && s_q.en;

    cif_ack_fmt #(
        .CPU_W (CPU_W)
    ) u_fmt (
        .grant_i   (grant),
        .win_id_i  (win_id),
        .sgi_src_i (sgi_src_i),
        .src_o     (ack_src),
        .word_o    (ack_word)
    );

    always_comb begin
        s_d         = s_q;
        reg_rdata_o = '0;
        ack_o       = 1'b0;
        ack_id_o    = '0;
        eoi_o       = 1'b0;
        eoi_id_o    = '0;

        // the retire word must match what acknowledge produced for that ID
        e_id     = reg_wdata_i[ID_W-1:0];
        e_expect = 32'(e_id);
        if (e_id < ID_W'(SGI_N)) begin
            e_expect[SRC_LSB +: CPU_W] = s_q.src[e_id[3:0]*CPU_W +: CPU_W];
        end
        e_hit = 1'b0;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (i[ID_W-1:0] == e_id && s_q.active[i]) begin
                e_hit = 1'b1;
            end
        end
        e_hit = e_hit && (reg_wdata_i == e_expect);

        case (reg_sel_e'(reg_sel_i))
            SEL_CTRL: begin
                if (reg_rd_i) reg_rdata_o = {31'b0, s_q.en};
                if (reg_wr_i) s_d.en = reg_wdata_i[0];
            end
            SEL_PMASK: begin
                if (reg_rd_i) reg_rdata_o = 32'(s_q.pmask);
                if (reg_wr_i) s_d.pmask = reg_wdata_i[PRIO_W-1:0];
            end
            SEL_ACK: begin
                if (reg_rd_i) begin
                    reg_rdata_o = ack_word;
                    if (grant) begin
                        ack_o    = 1'b1;
                        ack_id_o = win_id;
                        for (int i = 0; i < NUM_IDS; i++) begin
                            if (i[ID_W-1:0] == win_id) s_d.active[i] = 1'b1;
                        end
                        if (win_id < ID_W'(SGI_N)) begin
                            s_d.src[win_id[3:0]*CPU_W +: CPU_W] = ack_src;
                        end
                    end
                end
            end
            SEL_EOI: begin
                if (reg_wr_i && e_hit) begin
                    eoi_o    = 1'b1;
                    eoi_id_o = e_id;
                    for (int i = 0; i < NUM_IDS; i++) begin
                        if (i[ID_W-1:0] == e_id) s_d.active[i] = 1'b0;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.en     <= 1'b0;
            s_q.pmask  <= PRIO_W'(PMASK_RST);
            s_q.active <= '0;
            s_q.src    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o    = grant;
    assign active_o = s_q.active;
endmodule

// File: rtl/cif_chk.sv
module cif_chk
    import cif_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_i,
    input logic               ack_i,
    input logic [ID_W-1:0]    ack_id_i,
    input logic               eoi_i,
    input logic [ID_W-1:0]    eoi_id_i,
    input logic [NUM_IDS-1:0] active_i
);
    logic [ID_W-1:0] prev_ack_id_q;
    logic [ID_W-1:0] prev_eoi_id_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ack_id_q <= '0;
            prev_eoi_id_q <= '0;
        end else begin
            prev_ack_id_q <= ack_id_i;
            prev_eoi_id_q <= eoi_id_i;
        end
    end

    function automatic logic bit_at(input logic [NUM_IDS-1:0] v, input logic [ID_W-1:0] id);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (i[ID_W-1:0] == id) r = v[i];
        end
        return r;
    endfunction

    // R4
    ack_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> bit_at(active_i, prev_ack_id_q));

    // R4
    ack_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> irq_i);

    // R11
    ack_not_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> !bit_at(active_i, ack_id_i));

    // R7
    eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_i |=> !bit_at(active_i, prev_eoi_id_q));

    // R8
    eoi_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_i |-> bit_at(active_i, eoi_id_i));

    // R9
    ack_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> (ack_id_i <= ID_W'(ID_CAP)));

    // R7
    single_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_i, eoi_i}));
endmodule

bind cpu_if_core cif_chk #(.NUM_IDS(NUM_IDS)) u_cif_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_i    (irq_o),
    .ack_i    (ack_o),
    .ack_id_i (ack_id_o),
    .eoi_i    (eoi_o),
    .eoi_id_i (eoi_id_o),
    .active_i (active_o)
);

// File: tb/test_cpu_if_core.sv
module test_cpu_if_core;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 520;
    localparam int PW = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend = '0;
    logic [N*PW-1:0] prio = '0;
    logic [16*CW-1:0] sgi_src = '0;
    logic [1:0]    sel = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq, ack, eoi;
    logic [9:0]    ack_id, eoi_id;
    logic [N-1:0]  active;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [N-1:0] m_act = '0;
    logic         m_en = 1'b0;
    logic [7:0]   m_pmask = 8'hF0;
    logic [2:0]   m_src [16];

    cpu_if_core #(.NUM_IDS(N), .PRIO_W(PW), .CPU_W(CW)) i_cpu_if_core (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .prio_i(prio), .sgi_src_i(sgi_src),
        .reg_sel_i(sel), .reg_rd_i(rd_en), .reg_wr_i(wr_en), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .ack_o(ack), .ack_id_o(ack_id),
        .eoi_o(eoi), .eoi_id_o(eoi_id), .active_o(active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R2 R3: reference eligibility and winner
    function automatic int exp_win();
        int w = -1;
        int bp = 256;
        for (int i = 0; i <= 510; i++) begin
            if (pend[i] && !m_act[i] && int'(prio[i*PW +: PW]) < int'(m_pmask)
                && int'(prio[i*PW +: PW]) < bp) begin
                bp = int'(prio[i*PW +: PW]);
                w = i;
            end
        end
        return w;
    endfunction

    // R6: acknowledge word layout
    function automatic logic [31:0] word_of(input int id, input logic [2:0] s);
        logic [31:0] w;
        w = id;
        if (id < 16) w[12:10] = s;
        return w;
    endfunction

    task automatic set_prio(input int id, input int p);
        prio[id*PW +: PW] = p[7:0];
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d, output logic a, output logic [9:0] aid);
        @(negedge clk);
        sel = s; rd_en = 1'b1;
        #1;
        d = rdata; a = ack; aid = ack_id;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] v, output logic e, output logic [9:0] eid);
        @(negedge clk);
        sel = s; wr_en = 1'b1; wdata = v;
        #1;
        e = eoi; eid = eoi_id;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // acknowledge with model update and checks
    task automatic do_ack(input string req);
        int w;
        logic [31:0] d, ew;
        logic a;
        logic [9:0] aid;
        w = exp_win();
        if (m_en && w >= 0) ew = word_of(w, (w < 16) ? sgi_src[w*CW +: CW] : 3'd0);
        else ew = 32'd1023;
        rd(2'd2, d, a, aid);
        chk({req, " ack word"}, N'(d), N'(ew));
        chk({req, " ack pulse"}, N'(a), N'(m_en && w >= 0));
        if (m_en && w >= 0) begin
            chk({req, " ack id"}, N'(aid), N'(w));
            m_act[w] = 1'b1;
            if (w < 16) m_src[w] = sgi_src[w*CW +: CW];
        end
    endtask

    task automatic do_eoi(input string req, input logic [31:0] v);
        logic e;
        logic [9:0] eid;
        int id;
        bit hit;
        id = int'(v[9:0]);
        hit = (id < N) && m_act[id] && (v == word_of(id, (id < 16) ? m_src[id] : 3'd0));
        wr(2'd3, v, e, eid);
        chk({req, " eoi pulse"}, N'(e), N'(hit));
        if (hit) begin
            chk({req, " eoi id"}, N'(eid), N'(id));
            m_act[id] = 1'b0;
        end
    endtask

    task automatic post_chk(input string req);
        #1;
        chk({req, " R2 irq"}, N'(irq), N'(m_en && exp_win() >= 0));
        chk({req, " active"}, active, m_act);
    endtask

    task automatic clear_all();
        logic e;
        logic [9:0] eid;
        pend = '0;
        for (int i = 0; i < N; i++) begin
            if (m_act[i]) do_eoi("cleanup", word_of(i, (i < 16) ? m_src[i] : 3'd0));
        end
        wr(2'd0, 32'd1, e, eid);
        m_en = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, v;
        logic a, e;
        logic [9:0] aid, eid;
        int op, id;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) m_src[i] = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 irq", N'(irq), N'(0));
        chk("R1 active", active, '0);
        rd(2'd0, d, a, aid); chk("R1 ctrl", N'(d), N'(0));
        rd(2'd1, d, a, aid); chk("R1 pmask", N'(d), N'(8'hF0));

        // R10 control and mask registers
        wr(2'd1, 32'hFFFF_FF40, e, eid); m_pmask = 8'h40;
        rd(2'd1, d, a, aid); chk("R10 pmask low bits", N'(d), N'(32'h40));
        wr(2'd1, 32'hF0, e, eid); m_pmask = 8'hF0;
        wr(2'd0, 32'h3, e, eid); m_en = 1'b1;
        rd(2'd0, d, a, aid); chk("R10 enable readback", N'(d), N'(1));

        // R4 R11 single peripheral interrupt, kept pending
        pend[40] = 1'b1; set_prio(40, 8'h80);
        post_chk("R2 single");
        do_ack("R4 single");
        post_chk("R11 active excluded");
        // R7 R11 retire while still pending: re-signalled next cycle
        do_eoi("R7 retire", 32'd40);
        post_chk("R11 re-eligible");
        do_ack("R11 re-ack");
        clear_all();

        // R3 priority and tie order
        pend[30] = 1'b1; set_prio(30, 8'h10);
        pend[20] = 1'b1; set_prio(20, 8'h10);
        pend[25] = 1'b1; set_prio(25, 8'h20);
        do_ack("R3 tie lowest id");
        chk("R3 winner 20", N'(m_act[20]), N'(1));
        do_ack("R3 second");
        chk("R3 winner 30", N'(m_act[30]), N'(1));
        clear_all();

        // R2 R5 priority equal to mask is not eligible
        pend[50] = 1'b1; set_prio(50, 8'hF0);
        post_chk("R2 at mask");
        do_ack("R5 spurious");
        clear_all();

        // R6 R8 R7 software-generated interrupt with source field
        sgi_src[3*CW +: CW] = 3'd5;
        pend[3] = 1'b1; set_prio(3, 8'h00);
        do_ack("R6 sgi word");
        chk("R6 word 0x1403", N'(word_of(3, m_src[3])), N'(32'h1403));
        do_eoi("R8 missing source", 32'h0000_0003);
        post_chk("R8 kept active");
        do_eoi("R8 upper bits", 32'h0001_1403);
        do_eoi("R7 sgi retire", 32'h0000_1403);
        post_chk("R7 after sgi retire");
        clear_all();

        // R8 retire of an inactive peripheral id and bad source bits
        pend[60] = 1'b1; set_prio(60, 8'h01);
        do_ack("R8 setup");
        do_eoi("R8 inactive id", 32'd61);
        do_eoi("R8 stray field", 32'h0000_0400 | 32'd60);
        post_chk("R8 state kept");
        clear_all();

        // R9 cap at 510
        pend[511] = 1'b1; pend[515] = 1'b1; set_prio(511, 0); set_prio(515, 0);
        post_chk("R9 above cap");
        do_ack("R9 no ack above cap");
        pend[510] = 1'b1; set_prio(510, 8'h7F);
        do_ack("R9 id 510");
        clear_all();

        // R5 R10 disabled interface
        pend[70] = 1'b1; set_prio(70, 8'h05);
        wr(2'd0, 32'h0, e, eid); m_en = 1'b0;
        post_chk("R10 disabled");
        do_ack("R5 disabled ack");
        post_chk("R5 disabled state");
        clear_all();

        // random mix
        for (int it = 0; it < 400; it++) begin
            if (it % 8 == 0) begin
                for (int i = 0; i < N; i++) begin
                    pend[i] = ($urandom % 24) == 0;
                    prio[i*PW +: PW] = 8'($urandom);
                end
                sgi_src = 48'({$urandom, $urandom});
            end
            op = $urandom % 10;
            if (op < 4) begin
                do_ack("R4 random");
            end else if (op < 7) begin
                id = -1;
                for (int i = 0; i < N; i++) if (m_act[i] && id < 0) id = i;
                if (id >= 0) begin
                    v = word_of(id, (id < 16) ? m_src[id] : 3'd0);
                    if (op == 6) v = v ^ (32'h1 << ($urandom % 14));
                    do_eoi("R7 R8 random", v);
                end
            end else if (op == 7) begin
                v = 32'h60 + ($urandom % 160);
                wr(2'd1, v, e, eid); m_pmask = v[7:0];
            end else if (op == 8) begin
                v = ($urandom % 5) != 0;
                wr(2'd0, v, e, eid); m_en = v[0];
            end else begin
                do_eoi("R8 random junk", $urandom & 32'h1FFF);
            end
            post_chk("R2 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule